// File: doc/BRIEF.md
# Half-Precision to Integer Converter

This block turns a 16-bit IEEE-754 half-precision operand into a signed or unsigned integer of 32 or 64 bits. It sits in a floating-point execute path, next to the register-file write port. The caller presents the operand, the signedness, the target width and a rounding mode. One clock later the block returns a 64-bit integer and a 5-bit exception-flag vector. A 32-bit result is always sign-extended to fill the 64-bit destination.

The datapath has four parts. It splits the operand into its fields and classifies it. It aligns the significand to a fixed binary point and extracts a round bit and a sticky bit. It applies one of four rounding directions. Finally it range-checks the rounded magnitude against the chosen target.

Every value that cannot be represented saturates and raises only the invalid flag: NaNs, infinities, out-of-range magnitudes and negative values sent to an unsigned target. Every other result raises inexact exactly when discarded fraction bits were non-zero.

Top module: `h2i_convert`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `res_int` and `res_flags` are cleared to zero after that edge, whatever the operand inputs carry.
- R2: The result and flags for inputs present at a rising edge appear after that edge and hold until the next edge. The outputs do not change between edges.
- R3: The rounding-mode codes on `op_rmode` are:
  - 0: round to nearest, ties to even.
  - 1: round toward zero.
  - 2: round down.
  - 3: round up.
  - 4 to 7: behave as code 1.
  In `res_flags`, bit 4 is invalid (0x10) and bit 0 is inexact (0x01). Bits 3 to 1 are always zero, and invalid and inexact are never set together.
- R4: With round toward zero, fractional values truncate and raise only inexact: -1.1 (0xBC66) gives -1, 0.9 (0x3B33) and -0.9 (0xBB33) give 0, and 1.1 (0x3C66) gives 1.
- R5: Exactly representable values convert with no flag: 1.0 (0x3C00) gives 1, -1.0 (0xBC00) gives -1, 0x6803 gives 2054 and 0xE803 gives -2054.
- R6: Round to nearest breaks ties toward the even integer: 2.5 gives 2, 3.5 gives 4, 0.5 gives 0 and -2.5 gives -2. A non-tie such as 0.9 rounds to 1. All of these raise only inexact.
- R7: Round up moves toward positive infinity (1.1 gives 2, -1.1 gives -1). Round down moves toward negative infinity (-1.1 gives -2, 1.1 gives 1). All of these raise only inexact.
- R8: For an unsigned target (`op_signed`=0), a negative finite value whose rounded magnitude is non-zero gives 0 with invalid only. One whose rounded magnitude is zero gives 0 with inexact only. Examples:
  - -1.0, -3.0 and 0xE803 to 32 bits, and 0xE483 to 64 bits, each give 0 with invalid.
  - -0.9 toward zero gives 0 with inexact.
- R9: A NaN of either sign (quiet or signalling), +infinity and any positive magnitude above the target's range all saturate and raise invalid only:
  - signed 32-bit target: 0x000000007FFFFFFF;
  - signed 64-bit target: 0x7FFFFFFFFFFFFFFF;
  - unsigned target of either width: all 64 bits set.
- R10: -infinity and any negative magnitude below the signed target's range saturate and raise invalid only:
  - signed 32-bit target: 0xFFFFFFFF80000000;
  - signed 64-bit target: 0x8000000000000000;
  - unsigned target: 0.
- R11: Every 32-bit result is sign-extended from bit 31 into bits 63 to 32, including unsigned 32-bit results. For example, 65504 (0x7BFF) to unsigned 32 bits gives 0x000000000000FFE0, and -65504 (0xFBFF) to signed 32 bits gives 0xFFFFFFFFFFFF0020.
- R12: Zeros of either sign convert to 0 with no flag. Subnormals (exponent field 0, fraction non-zero) convert to 0 with inexact only under round to nearest and round toward zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_value | input | 16 | Half-precision operand: sign bit 15, exponent bits 14:10, fraction bits 9:0 |
| op_signed | input | 1 | 1 selects a signed integer target, 0 an unsigned one |
| op_wide | input | 1 | 1 selects a 64-bit target, 0 a 32-bit target |
| op_rmode | input | 3 | Rounding-mode code as listed in R3 |
| res_int | output | 64 | Converted integer; 32-bit results are sign-extended |
| res_flags | output | 5 | Exception flags: bit 4 invalid, bit 0 inexact |

## Verification
The block has one register stage, so the result and flags for an operand are due right after the first rising edge that samples it. The bench drives each operand on a falling edge and samples the outputs on the following falling edge, half a period after the capturing edge. One latency test also samples just before that edge, to show the earlier result is still held until the edge. The checks inside the RTL compare each output against the inputs taken one edge earlier, and are gated by a flag that is raised only after the first edge out of reset.

// File: rtl/h2i_pkg.sv
// Shared types and constants for the half-precision to integer converter.
// Assumes rounding-mode codes and flag bit positions fixed by the block's contract.
package h2i_pkg;

    typedef enum logic [2:0] {
        RM_NEAREST_EVEN = 3'd0,
        RM_TO_ZERO      = 3'd1,
        RM_DOWN         = 3'd2,
        RM_UP           = 3'd3
    } rmode_e;

    localparam int FLAG_W       = 5;
    localparam int FLAG_INVALID = 4;
    localparam int FLAG_INEXACT = 0;

endpackage

// File: rtl/h2i_unpack.sv
// Splits a floating-point operand into sign, exponent and significand and classifies it.
// Assumes IEEE-754 layout: sign on top, then EXP_W exponent bits, then MAN_W fraction bits.
module h2i_unpack #(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10,
    localparam int OP_W = 1 + EXP_W + MAN_W
) (
    input  logic [OP_W-1:0]  op,
    output logic             sign,
    output logic [EXP_W-1:0] exp_field,
    output logic [MAN_W:0]   mant,
    output logic             is_nan,
    output logic             is_inf
);
    logic [MAN_W-1:0] frac;
    logic             exp_ones;
    logic             exp_zero;

    // Field extraction and class decode.
    always_comb begin
        sign      = op[OP_W-1];
        exp_field = op[OP_W-2:MAN_W];
        frac      = op[MAN_W-1:0];
        exp_ones  = &exp_field;
        exp_zero  = ~|exp_field;
        mant      = {~exp_zero, frac};
        is_nan    = exp_ones & (|frac);
        is_inf    = exp_ones & ~(|frac);
    end

endmodule

// File: rtl/h2i_align.sv
// Places the significand on a fixed binary point and yields the integer part plus round and sticky bits.
// Assumes a finite operand; infinities and NaNs are overridden downstream.
module h2i_align #(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10,
    parameter int MAG_W = 17
) (
    input  logic [EXP_W-1:0] exp_field,
    input  logic [MAN_W:0]   mant,
    output logic [MAG_W-1:0] int_part,
    output logic             round_bit,
    output logic             sticky_bit
);
    localparam int                BIAS   = (2 ** (EXP_W - 1)) - 1;
    localparam int                FIX_W  = MAG_W + MAN_W;
    localparam logic [EXP_W-1:0]  BIAS_E = EXP_W'(BIAS);
    localparam logic [EXP_W-1:0]  HALF_E = EXP_W'(BIAS - 1);

    logic [FIX_W-1:0] fixed;

    // Split the value into integer part, first dropped bit, and OR of the rest.
    always_comb begin
        fixed      = '0;
        int_part   = '0;
        round_bit  = 1'b0;
        sticky_bit = 1'b0;
        if (exp_field == '0) begin
            sticky_bit = |mant;                      // zero or subnormal: below one half
        end else if (exp_field < HALF_E) begin
            sticky_bit = 1'b1;                       // normal value below one half
        end else if (exp_field == HALF_E) begin
            round_bit  = 1'b1;                       // value in [0.5, 1)
            sticky_bit = |mant[MAN_W-1:0];
        end else begin
            fixed      = FIX_W'(mant) << (exp_field - BIAS_E);
            int_part   = fixed[FIX_W-1:MAN_W];
            round_bit  = fixed[MAN_W-1];
            sticky_bit = |fixed[MAN_W-2:0];
        end
    end

endmodule

// File: rtl/h2i_round.sv
// Applies the selected rounding direction to a sign-magnitude integer with round/sticky bits.
// Assumes int_part leaves headroom for one increment (true when bits were discarded).
module h2i_round #(
    parameter int MAG_W = 17
) (
    input  logic [MAG_W-1:0] int_part,
    input  logic             round_bit,
    input  logic             sticky_bit,
    input  logic             sign,
    input  logic [2:0]       rmode,
    output logic [MAG_W-1:0] mag,
    output logic             inexact
);
    import h2i_pkg::*;

    logic lost;
    logic bump;

    // Decide whether the magnitude steps up by one, per rounding direction.
    always_comb begin
        lost = round_bit | sticky_bit;
        case (rmode)
            RM_NEAREST_EVEN: bump = round_bit & (sticky_bit | int_part[0]);
            RM_DOWN:         bump = sign & lost;
            RM_UP:           bump = ~sign & lost;
            default:         bump = 1'b0;            // toward zero, also codes 4..7
        endcase
        mag     = int_part + MAG_W'(bump);
        inexact = lost;
    end

endmodule

// File: rtl/h2i_range.sv
// Range-checks the rounded magnitude against the target and builds the final integer and flags.
// Assumes narrow results are sign-extended into the XLEN-bit destination.
module h2i_range #(
    parameter int XLEN     = 64,
    parameter int NARROW_W = 32,
    parameter int MAG_W    = 17
) (
    input  logic                     sign,
    input  logic                     is_nan,
    input  logic                     is_inf,
    input  logic [MAG_W-1:0]         mag,
    input  logic                     inexact,
    input  logic                     want_signed,
    input  logic                     want_wide,
    output logic [XLEN-1:0]          result,
    output logic [h2i_pkg::FLAG_W-1:0] flags
);
    import h2i_pkg::*;

    localparam int              CW       = ((MAG_W > XLEN) ? MAG_W : XLEN) + 1;
    localparam logic [XLEN-1:0] ALL1     = '1;
    localparam logic [XLEN-1:0] WIDE_MAX = {1'b0, {(XLEN-1){1'b1}}};
    localparam logic [XLEN-1:0] WIDE_MIN = {1'b1, {(XLEN-1){1'b0}}};
    localparam logic [XLEN-1:0] NAR_MAX  = XLEN'({1'b0, {(NARROW_W-1){1'b1}}});
    localparam logic [XLEN-1:0] NAR_MIN  = ~NAR_MAX;
    localparam logic [CW-1:0]   LP_W     = CW'(WIDE_MAX);
    localparam logic [CW-1:0]   LN_W     = CW'(WIDE_MIN);
    localparam logic [CW-1:0]   LU_W     = CW'(ALL1);
    localparam logic [CW-1:0]   LP_N     = CW'(NAR_MAX);
    localparam logic [CW-1:0]   LN_N     = CW'(NAR_MAX) + CW'(1);
    localparam logic [CW-1:0]   LU_N     = CW'({NARROW_W{1'b1}});

    logic [CW-1:0]   mag_x;
    logic [CW-1:0]   lim_pos;
    logic [CW-1:0]   lim_neg;
    logic [CW-1:0]   lim_uns;
    logic            sat_high;
    logic            sat_low;
    logic [XLEN-1:0] val_hi;
    logic [XLEN-1:0] val_lo;
    logic [XLEN-1:0] plain;

    // Pick the range limits for the selected target width.
    always_comb begin
        mag_x   = CW'(mag);
        lim_pos = want_wide ? LP_W : LP_N;
        lim_neg = want_wide ? LN_W : LN_N;
        lim_uns = want_wide ? LU_W : LU_N;
    end

    // Classify into saturate-high, saturate-low or in-range.
    always_comb begin
        sat_high = 1'b0;
        sat_low  = 1'b0;
        if (is_nan) begin
            sat_high = 1'b1;
        end else if (is_inf) begin
            sat_high = ~sign;
            sat_low  = sign;
        end else if (want_signed) begin
            sat_high = ~sign & (mag_x > lim_pos);
            sat_low  = sign & (mag_x > lim_neg);
        end else begin
            sat_high = ~sign & (mag_x > lim_uns);
            sat_low  = sign & (mag != '0);
        end
    end

    // Form saturation values and the in-range two's-complement value.
    always_comb begin
        val_hi = want_signed ? (want_wide ? WIDE_MAX : NAR_MAX) : ALL1;
        val_lo = want_signed ? (want_wide ? WIDE_MIN : NAR_MIN) : '0;
        plain  = XLEN'(mag);
        if (want_signed && sign) begin
            plain = -plain;
        end
        if (!want_wide) begin
            plain = {{(XLEN-NARROW_W){plain[NARROW_W-1]}}, plain[NARROW_W-1:0]};
        end
    end

    // Final selection; invalid suppresses inexact.
    always_comb begin
        flags = '0;
        if (sat_high || sat_low) begin
            result              = sat_high ? val_hi : val_lo;
            flags[FLAG_INVALID] = 1'b1;
        end else begin
            result              = plain;
            flags[FLAG_INEXACT] = inexact;
        end
    end

endmodule

// File: rtl/h2i_convert.sv
// Top: half-precision operand to 32/64-bit signed/unsigned integer, one register stage.
// Assumes inputs are stable at the rising edge; the outputs follow one edge later.
module h2i_convert #(
    parameter int EXP_W    = 5,
    parameter int MAN_W    = 10,
    parameter int XLEN     = 64,
    parameter int NARROW_W = 32,
    localparam int OP_W    = 1 + EXP_W + MAN_W,
    localparam int MAG_W   = (2 ** (EXP_W - 1)) + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [OP_W-1:0]            op_value,
    input  logic                       op_signed,
    input  logic                       op_wide,
    input  logic [2:0]                 op_rmode,
    output logic [XLEN-1:0]            res_int,
    output logic [h2i_pkg::FLAG_W-1:0] res_flags
);
    import h2i_pkg::*;

    logic             u_sign;
    logic [EXP_W-1:0] u_exp;
    logic [MAN_W:0]   u_mant;
    logic             u_nan;
    logic             u_inf;
    logic [MAG_W-1:0] a_int;
    logic             a_round;
    logic             a_sticky;
    logic [MAG_W-1:0] r_mag;
    logic             r_inexact;
    logic [XLEN-1:0]  c_result;
    logic [FLAG_W-1:0] c_flags;
    logic             out_live;

    h2i_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
        .op(op_value), .sign(u_sign), .exp_field(u_exp), .mant(u_mant),
        .is_nan(u_nan), .is_inf(u_inf)
    );

    h2i_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .MAG_W(MAG_W)) u_align (
        .exp_field(u_exp), .mant(u_mant), .int_part(a_int),
        .round_bit(a_round), .sticky_bit(a_sticky)
    );

    h2i_round #(.MAG_W(MAG_W)) u_round (
        .int_part(a_int), .round_bit(a_round), .sticky_bit(a_sticky),
        .sign(u_sign), .rmode(op_rmode), .mag(r_mag), .inexact(r_inexact)
    );

    h2i_range #(.XLEN(XLEN), .NARROW_W(NARROW_W), .MAG_W(MAG_W)) u_range (
        .sign(u_sign), .is_nan(u_nan), .is_inf(u_inf), .mag(r_mag),
        .inexact(r_inexact), .want_signed(op_signed), .want_wide(op_wide),
        .result(c_result), .flags(c_flags)
    );

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_int   <= '0;
            res_flags <= '0;
            out_live  <= 1'b0;
        end else begin
            res_int   <= c_result;
            res_flags <= c_flags;
            out_live  <= 1'b1;
        end
    end

    // R1: reset clears the outputs regardless of the operand.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (res_int == '0 && res_flags == '0));

    // R3: only invalid and inexact positions are used, never together.
    assert_flags_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_live |-> (res_flags[3:1] == '0 && !(res_flags[FLAG_INVALID] && res_flags[FLAG_INEXACT])));

    // R8: negative finite operand to unsigned target yields zero.
    assert_uns_neg_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_live && $past(!op_signed && op_value[OP_W-1] && !(&op_value[OP_W-2:MAN_W])))
        |-> (res_int == '0));

    // R9: any NaN operand raises invalid alone.
    assert_nan_invalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_live && $past((&op_value[OP_W-2:MAN_W]) && (|op_value[MAN_W-1:0])))
        |-> (res_flags == 5'h10));

    // R11: narrow results are sign-extended from the narrow top bit.
    assert_narrow_sext_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_live && $past(!op_wide))
        |-> (res_int[XLEN-1:NARROW_W] == {(XLEN-NARROW_W){res_int[NARROW_W-1]}}));

    // R12: zeros of either sign convert exactly to zero.
    assert_zero_exact_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_live && $past(op_value[OP_W-2:0] == '0))
        |-> (res_int == '0 && res_flags == '0));

endmodule

// File: tb/h2i_convert_tb.sv
// Directed bench for h2i_convert: one task per scenario, each checking its own results.
module h2i_convert_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_value = '0;
    logic        op_signed = 1'b0;
    logic        op_wide = 1'b0;
    logic [2:0]  op_rmode = 3'd1;
    logic [63:0] res_int;
    logic [4:0]  res_flags;

    int  tests_run = 0;
    int  tests_failed = 0;
    bit  done = 1'b0;

    localparam logic [2:0] RNE = 3'd0, RTZ = 3'd1, RDN = 3'd2, RUP = 3'd3;
    localparam logic [4:0] NF = 5'h00, NX = 5'h01, NV = 5'h10;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    h2i_convert u_dut (
        .clk(clk), .rst_n(rst_n), .op_value(op_value), .op_signed(op_signed),
        .op_wide(op_wide), .op_rmode(op_rmode), .res_int(res_int), .res_flags(res_flags)
    );

    always #5 clk = ~clk;   // 100 MHz

    // Compare outputs against expected values and log any mismatch.
    task automatic check(input string tag, input logic [63:0] er, input logic [4:0] ef);
        tests_run++;
        if (res_int !== er || res_flags !== ef) begin
            tests_failed++;
            $display("FAIL %s op=%h s=%0b w=%0b rm=%0d: got %h/%h expected %h/%h",
                     tag, op_value, op_signed, op_wide, op_rmode, res_int, res_flags, er, ef);
        end
    endtask

    // Drive on a falling edge, sample on the next falling edge (one rising edge later).
    task automatic conv(input string tag, input logic [15:0] v, input logic s, input logic w,
                        input logic [2:0] rm, input logic [63:0] er, input logic [4:0] ef);
        @(negedge clk);
        op_value = v; op_signed = s; op_wide = w; op_rmode = rm;
        @(negedge clk);
        check(tag, er, ef);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0; op_value = 16'h7E00; op_signed = 1'b1; op_wide = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 reset", 64'd0, NF);
        rst_n = 1'b1;
    endtask

    task automatic t_latency;
        conv("R2 settle", 16'h3C00, 1'b1, 1'b0, RTZ, 64'd1, NF);
        @(negedge clk);
        op_value = 16'h4300; op_rmode = RNE;
        @(posedge clk);
        #1;
        check("R2 after edge", 64'd4, NX);
        @(negedge clk);
        op_value = 16'h3C00; op_rmode = RTZ;
        #3;
        check("R2 held before edge", 64'd4, NX);
        @(negedge clk);
        check("R2 new value", 64'd1, NF);
    endtask

    task automatic t_encoding;
        conv("R3 code5 as toward zero", 16'h3B33, 1'b1, 1'b0, 3'd5, 64'd0, NX);
        conv("R3 code7 as toward zero", 16'h3C66, 1'b1, 1'b1, 3'd7, 64'd1, NX);
        conv("R3 code4 negative",       16'hBC66, 1'b1, 1'b0, 3'd4, ONES, NX);
    endtask

    task automatic t_rtz;
        conv("R4 -1.1",      16'hBC66, 1'b1, 1'b0, RTZ, ONES,  NX);
        conv("R4 -0.9",      16'hBB33, 1'b1, 1'b0, RTZ, 64'd0, NX);
        conv("R4 0.9",       16'h3B33, 1'b1, 1'b0, RTZ, 64'd0, NX);
        conv("R4 1.1",       16'h3C66, 1'b1, 1'b0, RTZ, 64'd1, NX);
        conv("R4 -1.1 wide", 16'hBC66, 1'b1, 1'b1, RTZ, ONES,  NX);
        conv("R4 1.1 uns",   16'h3C66, 1'b0, 1'b0, RTZ, 64'd1, NX);
    endtask

    task automatic t_exact;
        conv("R5 -1.0",         16'hBC00, 1'b1, 1'b0, RTZ, ONES, NF);
        conv("R5 1.0",          16'h3C00, 1'b1, 1'b0, RTZ, 64'd1, NF);
        conv("R5 2054",         16'h6803, 1'b1, 1'b0, RTZ, 64'd2054, NF);
        conv("R5 -2054",        16'hE803, 1'b1, 1'b0, RTZ, 64'hFFFF_FFFF_FFFF_F7FA, NF);
        conv("R5 2054 uns",     16'h6803, 1'b0, 1'b0, RTZ, 64'd2054, NF);
        conv("R5 -1155 wide",   16'hE483, 1'b1, 1'b1, RNE, 64'hFFFF_FFFF_FFFF_FB7D, NF);
    endtask

    task automatic t_rne;
        conv("R6 2.5",  16'h4100, 1'b1, 1'b0, RNE, 64'd2, NX);
        conv("R6 3.5",  16'h4300, 1'b1, 1'b0, RNE, 64'd4, NX);
        conv("R6 0.5",  16'h3800, 1'b1, 1'b0, RNE, 64'd0, NX);
        conv("R6 -2.5", 16'hC100, 1'b1, 1'b0, RNE, 64'hFFFF_FFFF_FFFF_FFFE, NX);
        conv("R6 0.9",  16'h3B33, 1'b1, 1'b0, RNE, 64'd1, NX);
    endtask

    task automatic t_directed;
        conv("R7 up 1.1",    16'h3C66, 1'b1, 1'b0, RUP, 64'd2, NX);
        conv("R7 up -1.1",   16'hBC66, 1'b1, 1'b0, RUP, ONES, NX);
        conv("R7 down -1.1", 16'hBC66, 1'b1, 1'b1, RDN, 64'hFFFF_FFFF_FFFF_FFFE, NX);
        conv("R7 down 1.1",  16'h3C66, 1'b1, 1'b0, RDN, 64'd1, NX);
    endtask

    task automatic t_uns_neg;
        conv("R8 -3.0",           16'hC200, 1'b0, 1'b0, RTZ, 64'd0, NV);
        conv("R8 -1.0",           16'hBC00, 1'b0, 1'b0, RTZ, 64'd0, NV);
        conv("R8 -0.9 tz",        16'hBB33, 1'b0, 1'b0, RTZ, 64'd0, NX);
        conv("R8 -2054 narrow",   16'hE803, 1'b0, 1'b0, RTZ, 64'd0, NV);
        conv("R8 -1155 wide",     16'hE483, 1'b0, 1'b1, RTZ, 64'd0, NV);
        conv("R8 -0.9 down",      16'hBB33, 1'b0, 1'b0, RDN, 64'd0, NV);
    endtask

    task automatic t_nan_pinf;
        conv("R9 -NaN s32",  16'hFE00, 1'b1, 1'b0, RTZ, 64'h0000_0000_7FFF_FFFF, NV);
        conv("R9 +NaN s32",  16'h7E00, 1'b1, 1'b0, RTZ, 64'h0000_0000_7FFF_FFFF, NV);
        conv("R9 +inf s32",  16'h7C00, 1'b1, 1'b0, RTZ, 64'h0000_0000_7FFF_FFFF, NV);
        conv("R9 -NaN s64",  16'hFE00, 1'b1, 1'b1, RTZ, 64'h7FFF_FFFF_FFFF_FFFF, NV);
        conv("R9 +inf s64",  16'h7C00, 1'b1, 1'b1, RNE, 64'h7FFF_FFFF_FFFF_FFFF, NV);
        conv("R9 sNaN u32",  16'h7C01, 1'b0, 1'b0, RTZ, ONES, NV);
        conv("R9 -NaN u64",  16'hFE00, 1'b0, 1'b1, RTZ, ONES, NV);
        conv("R9 +inf u32",  16'h7C00, 1'b0, 1'b0, RTZ, ONES, NV);
    endtask

    task automatic t_minf;
        conv("R10 -inf s32", 16'hFC00, 1'b1, 1'b0, RTZ, 64'hFFFF_FFFF_8000_0000, NV);
        conv("R10 -inf s64", 16'hFC00, 1'b1, 1'b1, RTZ, 64'h8000_0000_0000_0000, NV);
        conv("R10 -inf u32", 16'hFC00, 1'b0, 1'b0, RTZ, 64'd0, NV);
        conv("R10 -inf u64", 16'hFC00, 1'b0, 1'b1, RTZ, 64'd0, NV);
    endtask

    task automatic t_narrow;
        conv("R11 65504 u32",  16'h7BFF, 1'b0, 1'b0, RTZ, 64'h0000_0000_0000_FFE0, NF);
        conv("R11 -65504 s32", 16'hFBFF, 1'b1, 1'b0, RTZ, 64'hFFFF_FFFF_FFFF_0020, NF);
        conv("R11 -65504 s64", 16'hFBFF, 1'b1, 1'b1, RTZ, 64'hFFFF_FFFF_FFFF_0020, NF);
    endtask

    task automatic t_zero_sub;
        conv("R12 +0",          16'h0000, 1'b1, 1'b0, RNE, 64'd0, NF);
        conv("R12 -0",          16'h8000, 1'b1, 1'b1, RTZ, 64'd0, NF);
        conv("R12 -0 uns",      16'h8000, 1'b0, 1'b0, RTZ, 64'd0, NF);
        conv("R12 min sub",     16'h0001, 1'b1, 1'b0, RTZ, 64'd0, NX);
        conv("R12 neg sub rne", 16'h83FF, 1'b1, 1'b0, RNE, 64'd0, NX);
        conv("R12 sub uns",     16'h03FF, 1'b0, 1'b1, RNE, 64'd0, NX);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests_failed++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency();
        t_encoding();
        t_rtz();
        t_exact();
        t_rne();
        t_directed();
        t_uns_neg();
        t_nan_pinf();
        t_minf();
        t_narrow();
        t_zero_sub();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule